// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block decides whether one interrupt controller is a target of an inter-processor message. It holds three small registers that a simple write port loads: the local identifier, the logical destination identifier and the destination-format model. An incoming message supplies an 8-bit destination, a mode bit that picks physical or logical addressing, a 2-bit shorthand code and a flag that is set when this controller is the one sending the message. The block reports whether the message targets this controller on a single match bit.

The match output is combinational from the message inputs and the stored registers. Register writes take effect on the clock edge that samples them. A shorthand code other than zero decides the result alone. A zero code leaves the decision to the destination field, under physical or logical rules. Logical matching follows either a flat model, where the destination is a bit mask of controllers, or a cluster model, where the upper nibble names a cluster and the lower nibble is a member mask. When the format register holds neither model, logical messages never match. A sticky flag then records that a qualified logical message met the bad format.

Top module: `dest_match_unit`

## Requirements
- R1: After reset the local identifier equals the RESET_ID parameter, the logical identifier is 0 and the format model is flat (top nibble 0xF). A logical, unshorthanded message therefore does not match, and badFormat is 0.
- R2: With shorthand 0 and mode bit 0 (physical), match is 1 exactly when msgDest equals the local identifier or equals 0xFF.
- R3: With shorthand 0, mode bit 1 and the flat model, match is 1 exactly when (logical identifier AND msgDest) is nonzero.
- R4: With shorthand 0, mode bit 1 and the cluster model (top nibble 0x0), match is 1 exactly when the upper nibbles of the logical identifier and msgDest are equal and the AND of their lower nibbles is nonzero.
- R5: Shorthand 1 (self only) gives match equal to msgIsSelf.
- R6: Shorthand 2 (all including self) gives match 1.
- R7: Shorthand 3 (all excluding self) gives match equal to NOT msgIsSelf.
- R8: With a nonzero shorthand, msgDest and the mode bit have no effect on match.
- R9: A write with wrSel 2 loads bits [31:28] of wrData as the format model; bits [27:0] are treated as all ones and have no effect.
- R10: With a format nibble other than 0xF or 0x0, a logical unshorthanded message does not match. If msgValid is also high, badFormat goes high on the next clock edge and stays high until reset.
- R11: wrSel 0 loads the local identifier from wrData[31:24], and wrSel 1 loads the logical identifier from wrData[31:24]. The other data bits are ignored. wrSel 3 writes nothing.
- R12: A write becomes visible at match on the cycle after the clock edge that samples wrEn high. Nothing is written while wrEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 2 | Register select: 0 local ID, 1 logical ID, 2 format, 3 none |
| wrData | input | 32 | Write data |
| msgValid | input | 1 | Qualifies the message for the bad-format flag |
| msgDest | input | 8 | Message destination field |
| msgLogical | input | 1 | 1 = logical addressing, 0 = physical |
| msgShorthand | input | 2 | 0 use destination, 1 self, 2 all, 3 all but self |
| msgIsSelf | input | 1 | This controller is the sender |
| match | output | 1 | This controller is a target |
| badFormat | output | 1 | Sticky: a logical message met an unknown format |

## Verification
The bench builds the unit with its default widths: an 8-bit identifier, 32-bit write data and RESET_ID of 0x05. An 8-bit destination space makes the broadcast value 0xFF, nibble-split cluster decoding and random identifier collisions all likely within a few thousand random messages. The nonzero reset identifier lets the reset check separate an unwritten register from one cleared to zero. Format writes are biased toward the two valid nibbles, with some random nibbles mixed in, so the sticky flag is exercised both before and after it first sets.

// File: rtl/dest_match_pkg.sv
package dest_match_pkg;

  typedef enum logic [1:0] {
    SH_ADDR     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_ALL_BUT  = 2'd3
  } shorthand_e;

  // strobes from control to datapath
  typedef struct packed {
    logic idWr;
    logic lidWr;
    logic fmtWr;
    logic useAddr;
    logic selfOnly;
    logic allIncl;
    logic allExcl;
  } dmStrobes_t;

endpackage

// File: rtl/dest_match_ctrl.sv
module dest_match_ctrl
  import dest_match_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [1:0] msgShorthand,
  output dmStrobes_t strb
);

  shorthand_e shCode;
  assign shCode = shorthand_e'(msgShorthand);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (wrSel)
        2'd0:    strb.idWr  = 1'b1;
        2'd1:    strb.lidWr = 1'b1;
        2'd2:    strb.fmtWr = 1'b1;
        default: ;
      endcase
    end
    unique case (shCode)
      SH_ADDR:    strb.useAddr  = 1'b1;
      SH_SELF:    strb.selfOnly = 1'b1;
      SH_ALL:     strb.allIncl  = 1'b1;
      SH_ALL_BUT: strb.allExcl  = 1'b1;
      default:    ;
    endcase
  end

  // R11: at most one register written per cycle
  a_r11_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.idWr, strb.lidWr, strb.fmtWr}));
  // R8: exactly one message class active
  a_r8_one_class: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.useAddr, strb.selfOnly, strb.allIncl, strb.allExcl}) == 1);
  // R12: no write strobe without enable
  a_r12_no_write_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.idWr || strb.lidWr || strb.fmtWr));

endmodule

// File: rtl/dest_match_datapath.sv
module dest_match_datapath
  import dest_match_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ID_W     = 8,
  parameter int FMT_W    = 4,
  parameter logic [ID_W-1:0] RESET_ID = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              msgValid,
  input  logic [ID_W-1:0]   msgDest,
  input  logic              msgLogical,
  input  logic              msgIsSelf,
  output logic              match,
  output logic              badFormat
);

  localparam int NIB_W = ID_W / 2;
  localparam int HI_LSB = ID_W - NIB_W;

  logic [ID_W-1:0]  idQ;
  logic [ID_W-1:0]  lidQ;
  logic [FMT_W-1:0] fmtQ;
  logic             badQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ  <= RESET_ID;
      lidQ <= '0;
      fmtQ <= '1;
      badQ <= 1'b0;
    end else begin
      if (strb.idWr)  idQ  <= wrData[DATA_W-1 -: ID_W];
      if (strb.lidWr) lidQ <= wrData[DATA_W-1 -: ID_W];
      if (strb.fmtWr) fmtQ <= wrData[DATA_W-1 -: FMT_W];
      if (msgValid && fmtBad && strb.useAddr && msgLogical) badQ <= 1'b1;
    end
  end

  logic fmtFlat, fmtClus, fmtBad;
  logic physHit, flatHit, clusHit, logHit, addrHit;

  always_comb begin
    fmtFlat = (fmtQ == '1);
    fmtClus = (fmtQ == '0);
    fmtBad  = !fmtFlat && !fmtClus;
    physHit = (msgDest == idQ) || (msgDest == '1);
    flatHit = |(lidQ & msgDest);
    clusHit = (lidQ[ID_W-1:HI_LSB] == msgDest[ID_W-1:HI_LSB]) &&
              (|(lidQ[NIB_W-1:0] & msgDest[NIB_W-1:0]));
    logHit  = (fmtFlat && flatHit) || (fmtClus && clusHit);
    addrHit = msgLogical ? logHit : physHit;
    match   = (strb.useAddr && addrHit) || (strb.selfOnly && msgIsSelf) ||
              strb.allIncl || (strb.allExcl && !msgIsSelf);
  end

  assign badFormat = badQ;

  // R10: sticky flag never falls while out of reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    badQ |=> badQ);
  // R10: unknown format blocks logical matching
  a_r10_no_match_bad_fmt: assert property (@(posedge clk) disable iff (!rstN)
    (fmtBad && strb.useAddr && msgLogical) |-> !match);
  // R5: self-only never matches another sender's controller
  a_r5_self_only: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selfOnly && !msgIsSelf) |-> !match);
  // R7: excluding-self never matches the sender
  a_r7_excl_self: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allExcl && msgIsSelf) |-> !match);
  // R9: format held without a format write
  a_r9_fmt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fmtWr |=> $stable(fmtQ));
  // R2: broadcast always hits in physical mode
  a_r2_broadcast: assert property (@(posedge clk) disable iff (!rstN)
    (strb.useAddr && !msgLogical && msgDest == '1) |-> match);

endmodule

// File: rtl/dest_match_unit.sv
module dest_match_unit
  import dest_match_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ID_W     = 8,
  parameter int FMT_W    = 4,
  parameter logic [ID_W-1:0] RESET_ID = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              msgValid,
  input  logic [ID_W-1:0]   msgDest,
  input  logic              msgLogical,
  input  logic [1:0]        msgShorthand,
  input  logic              msgIsSelf,
  output logic              match,
  output logic              badFormat
);

  dmStrobes_t strb;

  dest_match_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrSel        (wrSel),
    .msgShorthand (msgShorthand),
    .strb         (strb)
  );

  dest_match_datapath #(
    .DATA_W   (DATA_W),
    .ID_W     (ID_W),
    .FMT_W    (FMT_W),
    .RESET_ID (RESET_ID)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .msgValid   (msgValid),
    .msgDest    (msgDest),
    .msgLogical (msgLogical),
    .msgIsSelf  (msgIsSelf),
    .match      (match),
    .badFormat  (badFormat)
  );

endmodule

// File: tb/dest_match_unit_bench.sv
`timescale 1ns/1ps
module dest_match_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        msgValid = 1'b0;
  logic [7:0]  msgDest = '0;
  logic        msgLogical = 1'b0;
  logic [1:0]  msgShorthand = '0;
  logic        msgIsSelf = 1'b0;
  logic        match, badFormat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mId, mLid;
  logic [3:0] mFmt;
  logic       mBad;

  always #2 clk = ~clk;

  dest_match_unit u_dest_match_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .msgValid(msgValid), .msgDest(msgDest), .msgLogical(msgLogical),
    .msgShorthand(msgShorthand), .msgIsSelf(msgIsSelf),
    .match(match), .badFormat(badFormat)
  );

  function automatic logic expMatch(logic [7:0] d, logic lg, logic [1:0] sh, logic self);
    case (sh)
      2'd1: return self;
      2'd2: return 1'b1;
      2'd3: return !self;
      default: begin
        if (!lg) return (d == mId) || (d == 8'hFF);
        if (mFmt == 4'hF) return (mLid & d) != 0;
        if (mFmt == 4'h0) return (mLid[7:4] == d[7:4]) && ((mLid[3:0] & d[3:0]) != 0);
        return 1'b0;
      end
    endcase
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic doWrite(logic [1:0] sel, logic [31:0] data, logic en = 1'b1);
    @(negedge clk);
    wrEn = en; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (en) begin
      case (sel)
        2'd0: mId  = data[31:24];
        2'd1: mLid = data[31:24];
        2'd2: mFmt = data[31:28];
        default: ;
      endcase
    end
  endtask

  task automatic sendMsg(string tag, logic [7:0] d, logic lg, logic [1:0] sh,
                         logic self, logic vld);
    @(negedge clk);
    msgDest = d; msgLogical = lg; msgShorthand = sh; msgIsSelf = self; msgValid = vld;
    #1;
    check(tag, match, expMatch(d, lg, sh, self));
    if (vld && sh == 2'd0 && lg && mFmt != 4'hF && mFmt != 4'h0) mBad = 1'b1;
    @(negedge clk);
    msgValid = 1'b0;
    #1;
    check("R10 flag", badFormat, mBad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h1234_5678));
    mId = 8'h05; mLid = 8'h00; mFmt = 4'hF; mBad = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1 check("R1 badFormat", badFormat, 1'b0);
    sendMsg("R1 logical after reset", 8'hFF, 1'b1, 2'd0, 1'b0, 1'b1);
    sendMsg("R1 reset id", 8'h05, 1'b0, 2'd0, 1'b0, 1'b1);
    sendMsg("R2 broadcast", 8'hFF, 1'b0, 2'd0, 1'b0, 1'b0);
    sendMsg("R2 miss", 8'h06, 1'b0, 2'd0, 1'b0, 1'b0);
    // R11 id from top byte, low bits ignored
    doWrite(2'd0, 32'h3AFF_FFFF);
    sendMsg("R11 id write", 8'h3A, 1'b0, 2'd0, 1'b0, 1'b0);
    sendMsg("R11 low bits ignored", 8'hFF - 8'h00, 1'b0, 2'd0, 1'b0, 1'b0);
    // R12 no write when wrEn low
    doWrite(2'd0, 32'h7700_0000, 1'b0);
    sendMsg("R12 no write", 8'h77, 1'b0, 2'd0, 1'b0, 1'b0);
    // R11 wrSel 3 writes nothing
    doWrite(2'd3, 32'h0000_0000);
    sendMsg("R11 sel3 fmt kept", 8'h01, 1'b1, 2'd0, 1'b0, 1'b0);
    sendMsg("R11 sel3 id kept", 8'h3A, 1'b0, 2'd0, 1'b0, 1'b0);
    // R3 flat
    doWrite(2'd1, 32'h2400_0000);
    sendMsg("R3 flat hit", 8'h04, 1'b1, 2'd0, 1'b0, 1'b0);
    sendMsg("R3 flat miss", 8'hDB, 1'b1, 2'd0, 1'b0, 1'b0);
    // R9 cluster, low bits of write forced
    doWrite(2'd2, 32'h0000_0000);
    sendMsg("R4 cluster hit", 8'h2C, 1'b1, 2'd0, 1'b0, 1'b0);
    sendMsg("R4 cluster wrong id", 8'h34, 1'b1, 2'd0, 1'b0, 1'b0);
    sendMsg("R4 cluster no member", 8'h2B, 1'b1, 2'd0, 1'b0, 1'b0);
    doWrite(2'd2, 32'hF000_0000);
    sendMsg("R9 back to flat", 8'h20, 1'b1, 2'd0, 1'b0, 1'b0);
    // R5 R6 R7 R8 shorthand
    sendMsg("R5 self", 8'h00, 1'b1, 2'd1, 1'b1, 1'b0);
    sendMsg("R5 not self", 8'hFF, 1'b0, 2'd1, 1'b0, 1'b0);
    sendMsg("R6 all", 8'h00, 1'b1, 2'd2, 1'b0, 1'b0);
    sendMsg("R7 all but self", 8'h3A, 1'b0, 2'd3, 1'b1, 1'b0);
    sendMsg("R7 other", 8'h00, 1'b1, 2'd3, 1'b0, 1'b0);
    sendMsg("R8 dest ignored", 8'h3A, 1'b0, 2'd1, 1'b0, 1'b0);
    // R10 bad format
    doWrite(2'd2, 32'h5000_0000);
    sendMsg("R10 no valid", 8'hFF, 1'b1, 2'd0, 1'b0, 1'b0);
    sendMsg("R10 physical ok", 8'h3A, 1'b0, 2'd0, 1'b0, 1'b1);
    sendMsg("R10 bad logical", 8'hFF, 1'b1, 2'd0, 1'b0, 1'b1);
    doWrite(2'd2, 32'hF000_0000);
    sendMsg("R10 sticky", 8'h04, 1'b1, 2'd0, 1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 3) begin
        logic [31:0] dat = $urandom;
        logic [1:0]  s = 2'($urandom_range(0, 3));
        if (s == 2'd2) begin
          int unsigned f = $urandom_range(0, 4);
          if (f < 2) dat[31:28] = 4'hF; else if (f < 4) dat[31:28] = 4'h0;
        end
        doWrite(s, dat, ($urandom_range(0, 7) != 0));
      end else begin
        logic [7:0] d = $urandom;
        if ($urandom_range(0, 3) == 0) d = mId;
        if ($urandom_range(0, 7) == 0) d = 8'hFF;
        sendMsg("R2-R10 random", d, 1'($urandom), 2'($urandom_range(0, 3)),
                1'($urandom), 1'($urandom));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule